// File: doc/BRIEF.md
# Statistics Endpoint with Reporting Filter

This block is a monitoring register for a hardware-based simulator. On the design side it looks like an ordinary register, with a write strobe, a data input and a data output, plus an increment strobe. That lets it take the place of an existing counter or state register without changes around it. A free-running target-time counter advances on every target step strobe.

On the monitoring side, a command port accepts one command at a time. Each command has an opcode, a target-time stamp and a payload. A command waits in a single pending slot until the target time equals its stamp, and only then takes effect. It can read the value, overwrite it, choose a reporting mode or set the reporting period.

A built-in filter decides when the block emits a record. It can emit periodically, when the counter wraps, or on every target step while a toggle switch is on. It can also stay silent. Each record holds the sampled value, the target time and a fixed source tag. Records leave through a one-entry valid/ready slot. If the slot is already full, a newer record replaces the older one and sets an overflow flag.

Top module: `stat_ep`

## Requirements
- R1: After reset the value is zero, the mode is off (code 0), the period is zero, the toggle switch is off, no record is valid, the overflow flag is clear and the command port is ready.
- R2: A design write (`d_we`) loads `d_in`, and the new value is visible on `q_out` after one clock. With `d_we` low, `d_inc` adds one modulo 2^DATA_W. A design write takes precedence over an increment.
- R3: In periodic mode (code 1) with period N > 0, a record is emitted on every Nth target step, counted from the last mode or period command. With N = 0 no periodic record is emitted.
- R4: In rollover mode (code 2), an increment that takes effect while the value is all ones wraps the value to zero and emits a record whose value is all ones.
- R5: Each cycle with `tgl_pulse` high flips a toggle switch. In toggle mode (code 3), a record is emitted on every target step while the switch is on.
- R6: A record carries the value as it stood in the trigger cycle (before that cycle's update), the target time in that cycle (the number of `tgt_step` cycles since reset, modulo 2^TIME_W), and the source tag SRC_ID.
- R7: An accepted command stays pending, with `cmd_ready` low, until the cycle in which the target time equals its stamp. It has no effect before that cycle, and the port is ready again in the following cycle.
- R8: Opcode values: 0 = read (emits one record in any mode), 1 = write (loads the payload), 2 = set mode (payload bits [1:0]), 3 = set period (payload bits [PER_W-1:0]). Commands with opcode 2 or 3 restart the period count.
- R9: When a matured command write and a design write or increment fall in the same cycle, the command write wins.
- R10: While `rec_ready` is low, a pending record holds its fields stable. A new record arriving while the slot is full replaces it and sets the sticky `rec_ovf` flag. `rec_valid` drops after a cycle with `rec_ready` high and no new record.
- R11: With the mode off, only read commands emit records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_we | input | 1 | Design write strobe |
| d_in | input | DATA_W | Design write data |
| d_inc | input | 1 | Design increment strobe |
| q_out | output | DATA_W | Register value |
| tgt_step | input | 1 | Advances target time by one |
| tgl_pulse | input | 1 | Flips the toggle switch |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | No command pending |
| cmd_op | input | 2 | Command opcode |
| cmd_time | input | TIME_W | Target time at which the command acts |
| cmd_data | input | DATA_W | Command payload |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record consumer ready |
| rec_value | output | DATA_W | Sampled value |
| rec_time | output | TIME_W | Target time of the sample |
| rec_src | output | TAG_W | Source tag |
| rec_ovf | output | 1 | Sticky record overwrite flag |

## Verification
The bench sweeps the period from 0 to 5 while skipping some target steps.

- A design that restarts its count from the wrong point, or counts clocks instead of steps, emits records in the wrong cycles.
- A design that treats a period of 0 as 1 emits records where none are expected.

Rollover is driven through the all-ones value with gaps in the increments. A record carrying zero, or one fired without an increment, is caught.

Commands with future stamps are checked for any early effect. A command write is made to collide with a design write, and a design that lets the design write win shows the wrong value. Back-pressure runs in toggle mode catch a slot that drops, shifts or fails to replace its record, and a missing overflow flag.

// File: rtl/stat_ep_pkg.sv
package stat_ep_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_MODE   = 2'd2,
    OP_PERIOD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RM_OFF      = 2'd0,
    RM_PERIODIC = 2'd1,
    RM_ROLLOVER = 2'd2,
    RM_TOGGLE   = 2'd3
  } rmode_e;

  // True when the step counter has reached the last step of a nonzero period.
  function automatic logic period_due(input logic [31:0] cnt, input logic [31:0] per);
    return (per != 32'd0) && (cnt == per - 32'd1);
  endfunction

  // A command matures once target time equals its stamp.
  function automatic logic stamp_due(input logic [31:0] now, input logic [31:0] stamp);
    return now == stamp;
  endfunction

endpackage

// File: rtl/stat_ep_cmd.sv
module stat_ep_cmd
  import stat_ep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TIME_W-1:0] cmd_time,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [TIME_W-1:0] cur_time,
  output logic              cmd_ready,
  output logic              mat_read,
  output logic              mat_write,
  output logic              mat_mode,
  output logic              mat_period,
  output logic [DATA_W-1:0] mat_data
);

  logic              pend_q;
  op_e               op_q;
  logic [TIME_W-1:0] stamp_q;
  logic [DATA_W-1:0] data_q;
  logic              mature;

  assign mature     = pend_q && stamp_due(32'(cur_time), 32'(stamp_q));
  assign cmd_ready  = !pend_q;
  assign mat_read   = mature && (op_q == OP_READ);
  assign mat_write  = mature && (op_q == OP_WRITE);
  assign mat_mode   = mature && (op_q == OP_MODE);
  assign mat_period = mature && (op_q == OP_PERIOD);
  assign mat_data   = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      op_q    <= OP_READ;
      stamp_q <= '0;
      data_q  <= '0;
    end else if (mature) begin
      pend_q <= 1'b0;
    end else if (cmd_valid && !pend_q) begin
      pend_q  <= 1'b1;
      op_q    <= op_e'(cmd_op);
      stamp_q <= cmd_time;
      data_q  <= cmd_data;
    end
  end

  assert_wait_stamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !mature) |=> (pend_q && $stable(stamp_q) && $stable(data_q)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mature |=> cmd_ready);

endmodule

// File: rtl/stat_ep_filter.sv
module stat_ep_filter
  import stat_ep_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode_we,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_per_we,
  input  logic [PER_W-1:0] cfg_per,
  input  logic             step,
  input  logic             tgl,
  input  logic             inc_eff,
  input  logic             at_max,
  output logic             fire
);

  rmode_e           mode_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] pcnt_q;
  logic             tog_q;
  logic             hit;
  logic             fire_per, fire_roll, fire_tog;

  assign hit       = period_due(32'(pcnt_q), 32'(per_q));
  assign fire_per  = (mode_q == RM_PERIODIC) && step && hit;
  assign fire_roll = (mode_q == RM_ROLLOVER) && inc_eff && at_max;
  assign fire_tog  = (mode_q == RM_TOGGLE) && tog_q && step;
  assign fire      = fire_per || fire_roll || fire_tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= RM_OFF;
      per_q  <= '0;
      pcnt_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (cfg_mode_we) mode_q <= rmode_e'(cfg_mode);
      if (cfg_per_we)  per_q  <= cfg_per;
      if (cfg_mode_we || cfg_per_we) begin
        pcnt_q <= '0;
      end else if (step && (mode_q == RM_PERIODIC) && (per_q != '0)) begin
        pcnt_q <= hit ? '0 : pcnt_q + 1'b1;
      end
      if (tgl) tog_q <= ~tog_q;
    end
  end

  assert_off_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_OFF) |-> !fire);

  assert_period_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (pcnt_q < per_q));

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tgl |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/stat_ep_outq.sv
module stat_ep_outq #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_val,
  input  logic [TIME_W-1:0] push_time,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [DATA_W-1:0] rec_value,
  output logic [TIME_W-1:0] rec_time,
  output logic              rec_ovf
);

  logic stalled;
  assign stalled = rec_valid && !rec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_value <= '0;
      rec_time  <= '0;
      rec_ovf   <= 1'b0;
    end else if (push) begin
      rec_valid <= 1'b1;
      rec_value <= push_val;
      rec_time  <= push_time;
      if (stalled) rec_ovf <= 1'b1;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !push) |=> (rec_valid && $stable(rec_value) && $stable(rec_time)));

  assert_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && push) |=> rec_ovf);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ovf |=> rec_ovf);

endmodule

// File: rtl/stat_ep.sv
module stat_ep
  import stat_ep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIME_W = 16,
  parameter int PER_W  = 16,
  parameter int TAG_W  = 8,
  parameter logic [TAG_W-1:0] SRC_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_we,
  input  logic [DATA_W-1:0] d_in,
  input  logic              d_inc,
  output logic [DATA_W-1:0] q_out,
  input  logic              tgt_step,
  input  logic              tgl_pulse,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [TIME_W-1:0] cmd_time,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [DATA_W-1:0] rec_value,
  output logic [TIME_W-1:0] rec_time,
  output logic [TAG_W-1:0]  rec_src,
  output logic              rec_ovf
);

  localparam logic [DATA_W-1:0] MAX_VAL = '1;

  logic [DATA_W-1:0] q;
  logic [TIME_W-1:0] tcur;
  logic              mat_read, mat_write, mat_mode, mat_period;
  logic [DATA_W-1:0] mat_data;
  logic              inc_eff, at_max, fire, push;

  assign inc_eff = d_inc && !d_we && !mat_write;
  assign at_max  = (q == MAX_VAL);
  assign push    = mat_read || fire;
  assign q_out   = q;
  assign rec_src = SRC_ID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      tcur <= '0;
    end else begin
      if (mat_write)    q <= mat_data;
      else if (d_we)    q <= d_in;
      else if (inc_eff) q <= q + 1'b1;
      if (tgt_step) tcur <= tcur + 1'b1;
    end
  end

  stat_ep_cmd #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_time(cmd_time), .cmd_data(cmd_data),
    .cur_time(tcur), .cmd_ready(cmd_ready),
    .mat_read(mat_read), .mat_write(mat_write), .mat_mode(mat_mode),
    .mat_period(mat_period), .mat_data(mat_data)
  );

  stat_ep_filter #(.PER_W(PER_W)) u_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode_we(mat_mode), .cfg_mode(mat_data[1:0]),
    .cfg_per_we(mat_period), .cfg_per(mat_data[PER_W-1:0]),
    .step(tgt_step), .tgl(tgl_pulse), .inc_eff(inc_eff), .at_max(at_max),
    .fire(fire)
  );

  stat_ep_outq #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_outq (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_val(q), .push_time(tcur),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_value(rec_value),
    .rec_time(rec_time), .rec_ovf(rec_ovf)
  );

  assert_cmd_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mat_write && (d_we || d_inc)) |=> (q_out == $past(mat_data)));

  assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_inc && !d_we && !mat_write) |=> (q_out == $past(q_out) + 1'b1));

  assert_read_emits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mat_read |=> (rec_valid && rec_value == $past(q_out) && rec_time == $past(tcur)));

endmodule

// File: tb/stat_ep_bench.sv
module stat_ep_bench;

  localparam int DW = 4;
  localparam int TW = 6;
  localparam int PW = 4;
  localparam int GW = 4;
  localparam logic [GW-1:0] SRC = 4'hA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          d_we = 0, d_inc = 0, tgt_step = 0, tgl_pulse = 0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic          cmd_valid = 0, cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [TW-1:0] cmd_time = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          rec_valid, rec_ready = 1'b1, rec_ovf;
  logic [DW-1:0] rec_value;
  logic [TW-1:0] rec_time;
  logic [GW-1:0] rec_src;

  always #5 clk = ~clk;

  stat_ep #(.DATA_W(DW), .TIME_W(TW), .PER_W(PW), .TAG_W(GW), .SRC_ID(SRC)) u_stat_ep (
    .clk(clk), .rst_n(rst_n), .d_we(d_we), .d_in(d_in), .d_inc(d_inc), .q_out(q_out),
    .tgt_step(tgt_step), .tgl_pulse(tgl_pulse), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_time(cmd_time), .cmd_data(cmd_data), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_value(rec_value), .rec_time(rec_time), .rec_src(rec_src),
    .rec_ovf(rec_ovf)
  );

  int checks = 0;
  int errors = 0;

  // Reference state, written from the requirements
  logic [DW-1:0] mq;
  logic [TW-1:0] mt;
  logic [PW-1:0] mpc, mper;
  logic [1:0]    mmode;
  logic          mtog, mpend;
  logic [1:0]    mop;
  logic [TW-1:0] mstamp;
  logic [DW-1:0] mdata;
  logic          sv, sovf;
  logic [DW-1:0] sval;
  logic [TW-1:0] stime;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq = '0; mt = '0; mpc = '0; mper = '0; mmode = 2'd0; mtog = 1'b0; mpend = 1'b0;
    mop = '0; mstamp = '0; mdata = '0; sv = 1'b0; sovf = 1'b0; sval = '0; stime = '0;
  endtask

  // One clock: drive, predict, clock, compare.
  task automatic cyc(input logic we, input logic [DW-1:0] din, input logic inc,
                     input logic step, input logic tgl, input logic rdy,
                     input logic cv, input logic [1:0] op, input logic [TW-1:0] ct,
                     input logic [DW-1:0] cd, input string req);
    logic mature, cwr, crd, einc, fp, fr, ft, ev;
    d_we = we; d_in = din; d_inc = inc; tgt_step = step; tgl_pulse = tgl; rec_ready = rdy;
    cmd_valid = cv; cmd_op = op; cmd_time = ct; cmd_data = cd;
    mature = mpend && (mt == mstamp);
    cwr  = mature && (mop == 2'd1);
    crd  = mature && (mop == 2'd0);
    einc = inc && !we && !cwr;
    fp   = (mmode == 2'd1) && (mper != 0) && step && (mpc == mper - 1'b1);
    fr   = (mmode == 2'd2) && einc && (mq == 4'hF);
    ft   = (mmode == 2'd3) && mtog && step;
    ev   = crd || fp || fr || ft;
    @(posedge clk);
    if (ev) begin
      if (sv && !rdy) sovf = 1'b1;
      sv = 1'b1; sval = mq; stime = mt;
    end else if (rdy) sv = 1'b0;
    if (mature && (mop == 2'd2 || mop == 2'd3)) mpc = '0;
    else if (step && mmode == 2'd1 && mper != 0) mpc = (mpc == mper - 1'b1) ? '0 : mpc + 1'b1;
    if (mature && mop == 2'd2) mmode = mdata[1:0];
    if (mature && mop == 2'd3) mper = mdata[PW-1:0];
    if (cwr) mq = mdata; else if (we) mq = din; else if (einc) mq = mq + 1'b1;
    if (tgl) mtog = ~mtog;
    if (step) mt = mt + 1'b1;
    if (mature) mpend = 1'b0;
    else if (cv && !mpend) begin mpend = 1'b1; mop = op; mstamp = ct; mdata = cd; end
    @(negedge clk);
    d_we = 0; d_inc = 0; tgt_step = 0; tgl_pulse = 0; cmd_valid = 0;
    chk(q_out == mq, "R2/R9 value", q_out, mq);
    chk(cmd_ready == !mpend, "R7 ready", cmd_ready, !mpend);
    chk(rec_valid == sv, req, rec_valid, sv);
    chk(rec_ovf == sovf, "R10 overflow", rec_ovf, sovf);
    if (sv && rec_valid) begin
      chk(rec_value == sval, "R6 value", rec_value, sval);
      chk(rec_time == stime, "R6 time", rec_time, stime);
      chk(rec_src == SRC, "R6 source", rec_src, SRC);
    end
  endtask

  task automatic idle(input int n, input logic step, input logic rdy, input string req);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, step, 0, rdy, 0, 2'd0, '0, '0, req);
  endtask

  // Issue a command dly target steps ahead and run until it has matured.
  task automatic cmd(input logic [1:0] op, input logic [DW-1:0] data, input int dly,
                     input logic bwe, input logic [DW-1:0] bdin, input logic binc,
                     input string req);
    cyc(0, '0, 0, 0, 0, 1, 1, op, mt + TW'(dly), data, req);
    for (int g = 0; g < 80 && mpend; g++) cyc(bwe, bdin, binc, 1, 0, 1, 0, 2'd0, '0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(q_out == 0, "R1 value", q_out, 0);
    chk(rec_valid == 0, "R1 valid", rec_valid, 0);
    chk(rec_ovf == 0, "R1 overflow", rec_ovf, 0);
    chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);
    idle(4, 1, 1, "R1 silent after reset");

    // R2 register behaviour
    cyc(1, 4'd5, 0, 0, 0, 1, 0, 0, '0, '0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, 1, 0, 1, 0, 0, '0, '0, "R2");
    cyc(1, 4'd2, 1, 0, 0, 1, 0, 0, '0, '0, "R2 write over inc");

    // R8 read in mode off, R11 silent while pending, R7 stamp wait
    cmd(2'd0, '0, 3, 0, '0, 1, "R8 R11 read");
    cmd(2'd1, 4'd9, 2, 1, 4'd3, 0, "R9 write collision");
    cmd(2'd1, 4'd6, 4, 0, '0, 1, "R9 write over inc");

    // R3 period sweep, including zero
    for (int n = 0; n < 6; n++) begin
      cmd(2'd3, 4'(n), 1, 0, '0, 0, "R3 set period");
      cmd(2'd2, 4'd1, 1, 0, '0, 0, "R3 set mode");
      for (int i = 0; i < 3 * n + 6; i++)
        cyc(0, '0, i[0], (i % 3) != 1, 0, 1, 0, 0, '0, '0, "R3 periodic");
    end

    // R4 rollover
    cmd(2'd2, 4'd2, 1, 0, '0, 0, "R4 set mode");
    cyc(1, 4'd12, 0, 0, 0, 1, 0, 0, '0, '0, "R4");
    for (int i = 0; i < 24; i++)
      cyc(0, '0, (i % 4) != 2, 1, 0, 1, 0, 0, '0, '0, "R4 rollover");

    // R5 toggle
    cmd(2'd2, 4'd3, 1, 0, '0, 0, "R5 set mode");
    for (int i = 0; i < 24; i++)
      cyc(0, '0, 1, i[0] | i[1], (i % 7) == 3, 1, 0, 0, '0, '0, "R5 toggle");

    // R10 back-pressure with records arriving
    if (!mtog) cyc(0, '0, 0, 0, 1, 1, 0, 0, '0, '0, "R5 switch on");
    for (int i = 0; i < 6; i++) cyc(0, '0, 1, 0, 0, 0, 0, 0, '0, '0, "R10 hold");
    for (int i = 0; i < 5; i++) cyc(0, '0, 1, 1, 0, 0, 0, 0, '0, '0, "R10 replace");
    idle(3, 0, 1, "R10 drain");

    // R11 mode off again, only reads emit
    cmd(2'd2, 4'd0, 1, 0, '0, 0, "R11 set off");
    for (int i = 0; i < 10; i++) cyc(0, '0, 1, 1, i[0], 1, 0, 0, '0, '0, "R11 off");
    cmd(2'd0, '0, 5, 0, '0, 1, "R8 read");
    idle(3, 1, 1, "R11 off");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule